// File: doc/BRIEF.md
# BCD Real-Time Clock with Freezable Host Bank

This core counts time of day and calendar in packed BCD: hundredths of seconds, seconds, minutes, hours, weekday, day of month, month and year. A one-cycle pulse on `tick_100hz` advances the count by one hundredth of a second. The count lives in an internal register set. A second bank of registers holds what the host reads.

The host talks to the core over a byte-wide register bus. A command bit can freeze the host bank so that a multi-byte read or write sees one consistent time. While the bank is frozen, the internal counters keep running. When the host sets the bit again, the next tick brings the bank up to date, so no time is lost. A host write to a time field loads both copies at once.

The month register also carries two control bits:
- An active-low oscillator run bit. While it is 1, ticks are ignored.
- An active-low enable for a 1024 Hz square wave. The square wave is produced by dividing a faster reference tick.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, the time fields read 00 for hundredths, seconds, minutes, hours and year, and 01 for weekday, date and month. The month register reads 0xC1, with the oscillator stopped and the square wave off. The command register (0xB) reads 0x80. `sqw_out` and `sqw_oe` are 0.
- R2: The register map is:
  - 0x0 hundredths
  - 0x1 seconds
  - 0x2 minutes
  - 0x4 hours
  - 0x6 weekday
  - 0x8 date
  - 0x9 month
  - 0xA year
  - 0xB command, with transfer enable in bit 7

  `bus_rdata` returns the addressed register one clock after `bus_addr` is presented. All other addresses read 0x00. Bits that are not implemented read 0: seconds, minutes and hours use mask 0x7F, weekday 0x07, date 0x3F, month 0xDF and command 0x80.
- R3: While month bit 7 is 1, `tick_100hz` pulses change no count.
- R4: While running, each tick advances hundredths in BCD. Hundredths roll from 99 to 00 and carry into seconds. Seconds and minutes roll from 59 to 00 and carry onward.
- R5: While command bit 7 is 0, the host bank holds its value across ticks.
- R6: The internal count advances while the host bank is frozen. The first tick after command bit 7 returns to 1 shows the full elapsed count.
- R7: A host write to a time field is visible at once, even while the bank is frozen. Counting then continues from the written value.
- R8: In 24-hour mode (hours bit 6 = 0), 23:59:59.99 rolls to 00:00:00.00, advances the date, and wraps weekday 7 to 1.
- R9: The date rolls after the last day of the month:
  - 30 in April, June, September and November
  - 28 in February, or 29 when the BCD year is divisible by 4
  - 31 in all other months

  December rolls to January of the next year, and year 99 rolls to 00.
- R10: In 12-hour mode (hours bit 6 = 1, bit 5 = PM), the hour sequence is:
  - 11 AM to 12 PM
  - 12 PM to 1 PM
  - 11 PM to 12 AM, which advances the date
  - 12 AM to 1 AM
- R11: Month bit 6 = 0 drives `sqw_oe` high. While the oscillator runs, `sqw_out` is a square wave with a period of `REF_PER_SQW` reference ticks. While the oscillator is stopped, `sqw_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_100hz | input | 1 | One-cycle pulse every hundredth of a second |
| ref_tick | input | 1 | Reference pulse, `REF_PER_SQW` per square-wave period |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| sqw_out | output | 1 | Square-wave output |
| sqw_oe | output | 1 | Square-wave output enable |

## Verification
The timing of each result is:
- A tick or write taken at a clock edge changes both banks at that edge.
- Read data for an address appears one edge after the address is presented.
- `sqw_oe` follows a month write by one further edge.

The bench drives every input at a falling edge. It reads a register by presenting the address, waiting one full cycle, and sampling on the next falling edge. It checks `sqw_oe` two falling edges after the write. It measures the square-wave period as falling-edge counts between rising levels, so every sample lands half a cycle after the edge that produced it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [3:0] ADR_HUND = 4'h0;
  localparam logic [3:0] ADR_SEC  = 4'h1;
  localparam logic [3:0] ADR_MIN  = 4'h2;
  localparam logic [3:0] ADR_HOUR = 4'h4;
  localparam logic [3:0] ADR_WDAY = 4'h6;
  localparam logic [3:0] ADR_DATE = 4'h8;
  localparam logic [3:0] ADR_MON  = 4'h9;
  localparam logic [3:0] ADR_YEAR = 4'hA;
  localparam logic [3:0] ADR_CMD  = 4'hB;

  typedef struct packed {
    logic [7:0] hund;
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{hund: 8'h00, sec: 8'h00, min: 8'h00,
                                     hour: 8'h00, wday: 8'h01, date: 8'h01,
                                     mon: 8'h01, year: 8'h00};

  // BCD increment of a two-digit value (no wrap handling)
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // Implemented bits of each time field as stored in the core
  function automatic logic [7:0] field_mask(input logic [3:0] a);
    case (a)
      ADR_HUND, ADR_YEAR:         return 8'hFF;
      ADR_SEC, ADR_MIN, ADR_HOUR: return 8'h7F;
      ADR_WDAY:                   return 8'h07;
      ADR_DATE:                   return 8'h3F;
      ADR_MON:                    return 8'h1F;
      default:                    return 8'h00;
    endcase
  endfunction

  function automatic logic is_time_addr(input logic [3:0] a);
    return field_mask(a) != 8'h00;
  endfunction

  // Last day of month m (BCD) in year y (BCD)
  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    case (m)
      8'h02:                      return (r == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Hour advance; bit 8 of the result is the carry into the date
  function automatic logic [8:0] hour_inc(input logic [7:0] h);
    logic [4:0] hv;
    logic       pm;
    if (h[6]) begin
      hv = h[4:0];
      pm = h[5];
      if (hv == 5'h11)      return {pm, 1'b0, 1'b1, ~pm, 5'h12};
      else if (hv == 5'h12) return {1'b0, 1'b0, 1'b1, pm, 5'h01};
      else begin
        hv = bcd_inc({3'b000, hv})[4:0];
        return {1'b0, 1'b0, 1'b1, pm, hv};
      end
    end else begin
      if (h[5:0] == 6'h23) return 9'h100;
      return {1'b0, 2'b00, bcd_inc({2'b00, h[5:0]})[5:0]};
    end
  endfunction

endpackage

// File: rtl/rtc_timecore.sv
module rtc_timecore
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       wr,
  input  logic [3:0] waddr,
  input  logic [7:0] wdata,
  output rtc_time_t  cur,
  output rtc_time_t  nxt
);

  rtc_time_t inc;
  logic      cy;
  logic [8:0] hr;
  logic [7:0] wd;

  always_comb begin
    inc = cur;
    cy  = 1'b0;
    hr  = 9'h000;
    if (step) begin
      if (cur.hund == 8'h99) begin inc.hund = 8'h00; cy = 1'b1; end
      else inc.hund = bcd_inc(cur.hund);
      if (cy) begin
        if (cur.sec == 8'h59) inc.sec = 8'h00;
        else begin inc.sec = bcd_inc(cur.sec); cy = 1'b0; end
      end
      if (cy) begin
        if (cur.min == 8'h59) inc.min = 8'h00;
        else begin inc.min = bcd_inc(cur.min); cy = 1'b0; end
      end
      if (cy) begin
        hr       = hour_inc(cur.hour);
        inc.hour = hr[7:0];
        cy       = hr[8];
      end
      if (cy) begin
        inc.wday = (cur.wday == 8'h07) ? 8'h01 : bcd_inc(cur.wday);
        if (cur.date == month_len(cur.mon, cur.year)) inc.date = 8'h01;
        else begin inc.date = bcd_inc(cur.date); cy = 1'b0; end
      end
      if (cy) begin
        if (cur.mon == 8'h12) inc.mon = 8'h01;
        else begin inc.mon = bcd_inc(cur.mon); cy = 1'b0; end
      end
      if (cy) inc.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
    end
  end

  // Host write overrides the addressed field in the same edge
  always_comb begin
    nxt = inc;
    wd  = wdata & field_mask(waddr);
    if (wr) begin
      case (waddr)
        ADR_HUND: nxt.hund = wd;
        ADR_SEC:  nxt.sec  = wd;
        ADR_MIN:  nxt.min  = wd;
        ADR_HOUR: nxt.hour = wd;
        ADR_WDAY: nxt.wday = wd;
        ADR_DATE: nxt.date = wd;
        ADR_MON:  nxt.mon  = wd;
        ADR_YEAR: nxt.year = wd;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= TIME_RST;
    else     cur <= nxt;
  end

endmodule

// File: rtl/rtc_sqw.sv
module rtc_sqw #(
  parameter int HALF = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ref_tick,
  output logic sqw
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sqw <= 1'b0;
    end else if (ref_tick) begin
      if (cnt == LAST) begin
        cnt <= '0;
        sqw <= ~sqw;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int REF_PER_SQW = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_100hz,
  input  logic       ref_tick,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sqw_out,
  output logic       sqw_oe
);

  localparam int HALF = (REF_PER_SQW >= 2) ? REF_PER_SQW / 2 : 1;

  logic      osc_n;
  logic      sqw_n;
  logic      te;
  logic      step;
  rtc_time_t core_cur;
  rtc_time_t core_nxt;
  rtc_time_t vis;
  rtc_time_t vis_nxt;
  logic [7:0] rd_mux;
  logic [7:0] wd;

  assign step = tick_100hz && !osc_n;

  rtc_timecore u_core (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .wr   (bus_wr),
    .waddr(bus_addr),
    .wdata(bus_wdata),
    .cur  (core_cur),
    .nxt  (core_nxt)
  );

  rtc_sqw #(.HALF(HALF)) u_sqw (
    .clk     (clk),
    .rst     (rst),
    .run     (!osc_n),
    .ref_tick(ref_tick),
    .sqw     (sqw_out)
  );

  // Host bank: follows the core on ticks while transfer is enabled,
  // and always takes host writes
  always_comb begin
    vis_nxt = (step && te) ? core_nxt : vis;
    wd      = bus_wdata & field_mask(bus_addr);
    if (bus_wr) begin
      case (bus_addr)
        ADR_HUND: vis_nxt.hund = wd;
        ADR_SEC:  vis_nxt.sec  = wd;
        ADR_MIN:  vis_nxt.min  = wd;
        ADR_HOUR: vis_nxt.hour = wd;
        ADR_WDAY: vis_nxt.wday = wd;
        ADR_DATE: vis_nxt.date = wd;
        ADR_MON:  vis_nxt.mon  = wd;
        ADR_YEAR: vis_nxt.year = wd;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis   <= TIME_RST;
      osc_n <= 1'b1;
      sqw_n <= 1'b1;
      te    <= 1'b1;
    end else begin
      vis <= vis_nxt;
      if (bus_wr && bus_addr == ADR_MON) begin
        osc_n <= bus_wdata[7];
        sqw_n <= bus_wdata[6];
      end
      if (bus_wr && bus_addr == ADR_CMD) te <= bus_wdata[7];
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_HUND: rd_mux = vis.hund;
      ADR_SEC:  rd_mux = vis.sec;
      ADR_MIN:  rd_mux = vis.min;
      ADR_HOUR: rd_mux = vis.hour;
      ADR_WDAY: rd_mux = vis.wday;
      ADR_DATE: rd_mux = vis.date;
      ADR_MON:  rd_mux = {osc_n, sqw_n, vis.mon[5:0]};
      ADR_YEAR: rd_mux = vis.year;
      ADR_CMD:  rd_mux = {te, 7'b0};
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
      sqw_oe    <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      sqw_oe    <= !sqw_n;
    end
  end

endmodule

// File: rtl/bcd_rtc_checks.sv
module bcd_rtc_checks (
  input logic       clk,
  input logic       rst,
  input logic [3:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic       tick_100hz,
  input logic       osc_n,
  input logic       te,
  input logic [7:0] vis_hund,
  input logic [7:0] int_hund,
  input logic       sqw_out
);

  assert_unused_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 4'h3) |=> (bus_rdata == 8'h00));

  assert_stopped_core_R3: assert property (@(posedge clk) disable iff (rst)
    (osc_n && !bus_wr) |=> $stable(int_hund));

  assert_hund_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_100hz && !osc_n && !bus_wr && int_hund == 8'h00) |=> (int_hund == 8'h01));

  assert_frozen_bank_R5: assert property (@(posedge clk) disable iff (rst)
    (!te && !bus_wr) |=> $stable(vis_hund));

  assert_sqw_low_R11: assert property (@(posedge clk) disable iff (rst)
    osc_n |=> !sqw_out);

endmodule

bind bcd_rtc bcd_rtc_checks u_checks (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .tick_100hz(tick_100hz),
  .osc_n     (osc_n),
  .te        (te),
  .vis_hund  (vis.hund),
  .int_hund  (core_cur.hund),
  .sqw_out   (sqw_out)
);

// File: tb/test_bcd_rtc.sv
module test_bcd_rtc;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_100hz = 1'b0;
  logic       ref_tick = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sqw_out;
  logic       sqw_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bcd_rtc #(.REF_PER_SQW(32)) i_bcd_rtc (
    .clk(clk), .rst(rst), .tick_100hz(tick_100hz), .ref_tick(ref_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sqw_out(sqw_out), .sqw_oe(sqw_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_100hz = 1'b1;
      @(negedge clk); tick_100hz = 1'b0;
    end
  endtask

  task automatic set_last_hundredth(input logic [7:0] hour);
    wr(4'h4, hour); wr(4'h2, 8'h59); wr(4'h1, 8'h59); wr(4'h0, 8'h99);
  endtask

  task automatic t_reset;
    expect_reg("R1 hund", 4'h0, 8'h00);
    expect_reg("R1 hour", 4'h4, 8'h00);
    expect_reg("R1 wday", 4'h6, 8'h01);
    expect_reg("R1 date", 4'h8, 8'h01);
    expect_reg("R1 month", 4'h9, 8'hC1);
    expect_reg("R1 year", 4'hA, 8'h00);
    expect_reg("R1 cmd", 4'hB, 8'h80);
    check("R1 sqw_oe", sqw_oe, 0);
    check("R1 sqw_out", sqw_out, 0);
  endtask

  task automatic t_masks;
    wr(4'h1, 8'hFF); expect_reg("R2 sec mask", 4'h1, 8'h7F);
    wr(4'h6, 8'hFF); expect_reg("R2 wday mask", 4'h6, 8'h07);
    wr(4'h8, 8'hFF); expect_reg("R2 date mask", 4'h8, 8'h3F);
    wr(4'h9, 8'hFF); expect_reg("R2 month mask", 4'h9, 8'hDF);
    wr(4'hB, 8'h7F); expect_reg("R2 cmd mask", 4'hB, 8'h00);
    wr(4'hB, 8'hFF); expect_reg("R2 cmd mask", 4'hB, 8'h80);
    wr(4'h3, 8'hFF); expect_reg("R2 unused addr", 4'h3, 8'h00);
    wr(4'hE, 8'hFF); expect_reg("R2 unused addr", 4'hE, 8'h00);
    wr(4'h1, 8'h00); wr(4'h6, 8'h01); wr(4'h8, 8'h01); wr(4'h9, 8'hC1);
  endtask

  task automatic t_osc_stop;
    wr(4'h0, 8'h00);
    ticks(5);
    expect_reg("R3 stopped hund", 4'h0, 8'h00);
    expect_reg("R3 stopped sec", 4'h1, 8'h00);
  endtask

  task automatic t_count;
    wr(4'h9, 8'h41);
    wr(4'h0, 8'h00);
    ticks(13);
    expect_reg("R4 hund count", 4'h0, 8'h13);
    wr(4'h4, 8'h05); wr(4'h2, 8'h59); wr(4'h1, 8'h59); wr(4'h0, 8'h98);
    ticks(2);
    expect_reg("R4 hund roll", 4'h0, 8'h00);
    expect_reg("R4 sec roll", 4'h1, 8'h00);
    expect_reg("R4 min roll", 4'h2, 8'h00);
    expect_reg("R4 hour carry", 4'h4, 8'h06);
  endtask

  task automatic t_freeze;
    wr(4'h0, 8'h10); wr(4'h1, 8'h20);
    wr(4'hB, 8'h00);
    ticks(30);
    expect_reg("R5 frozen hund", 4'h0, 8'h10);
    wr(4'h1, 8'h45);
    expect_reg("R7 write while frozen", 4'h1, 8'h45);
    wr(4'hB, 8'h80);
    expect_reg("R5 held before tick", 4'h0, 8'h10);
    ticks(1);
    expect_reg("R6 resumed hund", 4'h0, 8'h41);
    expect_reg("R7 sec kept", 4'h1, 8'h45);
  endtask

  task automatic t_24h;
    wr(4'h6, 8'h07); wr(4'h8, 8'h15); wr(4'h9, 8'h41);
    set_last_hundredth(8'h23);
    ticks(1);
    expect_reg("R8 hour wrap", 4'h4, 8'h00);
    expect_reg("R8 wday wrap", 4'h6, 8'h01);
    expect_reg("R8 date adv", 4'h8, 8'h16);
  endtask

  task automatic month_case(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y,
                            input logic [7:0] ed, input logic [7:0] em, input logic [7:0] ey);
    wr(4'hA, y); wr(4'h9, 8'h40 | m); wr(4'h8, d);
    set_last_hundredth(8'h23);
    ticks(1);
    expect_reg("R9 date", 4'h8, ed);
    expect_reg("R9 month", 4'h9, 8'h40 | em);
    expect_reg("R9 year", 4'hA, ey);
  endtask

  task automatic t_months;
    month_case(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, 8'h21);
    month_case(8'h30, 8'h01, 8'h21, 8'h31, 8'h01, 8'h21);
    month_case(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
    month_case(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
    month_case(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, 8'h12);
    month_case(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
    month_case(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_12h;
    wr(4'h8, 8'h10); wr(4'h9, 8'h41);
    set_last_hundredth(8'h51);
    ticks(1);
    expect_reg("R10 11AM to 12PM", 4'h4, 8'h72);
    set_last_hundredth(8'h72);
    ticks(1);
    expect_reg("R10 12PM to 1PM", 4'h4, 8'h61);
    set_last_hundredth(8'h71);
    ticks(1);
    expect_reg("R10 11PM to 12AM", 4'h4, 8'h52);
    expect_reg("R10 date adv", 4'h8, 8'h11);
    set_last_hundredth(8'h52);
    ticks(1);
    expect_reg("R10 12AM to 1AM", 4'h4, 8'h41);
  endtask

  task automatic t_sqw;
    int n;
    int guard;
    ref_tick = 1'b1;
    wr(4'h9, 8'h01);
    @(negedge clk);
    check("R11 oe on", sqw_oe, 1);
    guard = 0;
    while (sqw_out !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    while (sqw_out !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    n = 0;
    while (sqw_out === 1'b1 && n < 200) begin @(negedge clk); n++; end
    check("R11 high half", n, 16);
    while (sqw_out === 1'b0 && n < 200) begin @(negedge clk); n++; end
    check("R11 period", n, 32);
    wr(4'h9, 8'h81);
    n = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sqw_out !== 1'b0) n++;
    end
    check("R11 low when stopped", n, 0);
    check("R11 oe kept", sqw_oe, 1);
    wr(4'h9, 8'hC1);
    @(negedge clk);
    check("R11 oe off", sqw_oe, 0);
    ref_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_masks;
    t_osc_stop;
    t_count;
    t_freeze;
    t_24h;
    t_months;
    t_12h;
    t_sqw;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule